// File: doc/BRIEF.md
# Command-List DMA Control Register Block

This block holds the control and status registers for a display-list command processor. A host reaches it over a plain 32-bit register bus, where every write carries a per-bit mask. It keeps three pointers for a command list: start, end and current. It also keeps a small status word and a bank of span registers. A set of read-only locations always reads zero. Fetching commands, moving data and drawing are handled elsewhere. This block only records what the host programs and reports back.

The status word cannot be written directly. Each write to the status address is decoded as commands: each flag has a clear bit and a set bit. If a write clears the freeze flag while the neighbouring vector coprocessor is neither halted nor broken, the block sends that coprocessor a single-cycle restart pulse. Writing the end pointer, or a completion event from the command engine, produces a single-cycle interrupt pulse toward the host's interrupt controller.

Top module: `cmdlist_ctrl_regs`

## Requirements
- R1: While reset is asserted, every register is cleared on the clock edge. After reset, every address reads zero, and both pulse outputs are low.
- R2: Word address map: 0 start pointer, 1 end pointer, 2 current pointer, 3 status, 4 to 7 read-only zero locations, 8 to 11 span registers 0 to 3, 12 to 15 unmapped (read zero). Writes to start, end and the span registers store `(old & ~mask) | (wdata & mask)`.
- R3: A write to the start pointer also loads the merged new start value into the current pointer, on the same edge.
- R4: A write to the end pointer makes `irq_pulse` high for exactly the one cycle after the write edge.
- R5: In a status write, command bit 0 clears status bit 0 (the memory-source flag) and command bit 1 sets it. If both are given, the flag ends up set.
- R6: In a status write, command bits 2 and 3 clear and set status bit 1 (freeze), and command bits 4 and 5 clear and set status bit 2 (flush). If both bits of a pair are given, the flag ends up set.
- R7: A status write whose effective command has bit 2 set, made while `cop_halt` and `cop_broke` are both low, makes `task_restart` high for the one cycle after the write edge. If either input is high, there is no pulse.
- R8: Writes to the current pointer, the status word (as data), addresses 4 to 7 and addresses 12 to 15 store no data. The current pointer changes only through R3.
- R9: `done_evt` clears status bit 1, sets status bits 0 and 7, and gives a one-cycle `irq_pulse`. It overrides a status write in the same cycle.
- R10: Only command bits whose mask bit is 1 take effect in a status write. A status write with a zero mask changes nothing and gives no restart pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_addr | input | 4 | Word address |
| bus_wdata | input | 32 | Write data |
| bus_wmask | input | 32 | Per-bit write mask |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| done_evt | input | 1 | Completion event from the command engine |
| cop_halt | input | 1 | Vector coprocessor is halted |
| cop_broke | input | 1 | Vector coprocessor hit a break |
| irq_pulse | output | 1 | One-cycle interrupt request toward the host |
| task_restart | output | 1 | One-cycle restart request to the coprocessor |

## Verification
A wrong flag or pointer shows up on `bus_rdata` as soon as its address is read. The read path is combinational, so the bench reads the written location and the status word in the same cycle a write or event lands. A wrong decode of the clear/set pairs, or of their priority against a completion event, shows as a wrong status bit right after that edge. A wrong trigger for either pulse shows one cycle after the causing edge as a missing or extra `irq_pulse` or `task_restart`.

// File: rtl/cmdlist_pkg.sv
// Package: shared address codes, status bit positions and the masked-merge
// helper used by the command-list control register block.
package cmdlist_pkg;

    // Word addresses of the control window
    localparam int unsigned A_START   = 0;
    localparam int unsigned A_END     = 1;
    localparam int unsigned A_CURRENT = 2;
    localparam int unsigned A_STATUS  = 3;
    // First word address of the span bank
    localparam int unsigned A_SPAN0   = 8;

    // Status bit positions
    localparam int unsigned ST_SRC    = 0;
    localparam int unsigned ST_FREEZE = 1;
    localparam int unsigned ST_FLUSH  = 2;
    localparam int unsigned ST_DONE   = 7;

    // Number of clear/set command pairs in a status write
    localparam int unsigned N_PAIRS   = 3;

    // Per-bit masked merge of new data into an old value
    function automatic logic [31:0] masked_merge(input logic [31:0] old_v,
                                                 input logic [31:0] new_v,
                                                 input logic [31:0] msk);
        return (old_v & ~msk) | (new_v & msk);
    endfunction

endpackage

// File: rtl/cl_status_ctrl.sv
// Status flag unit. Holds the source, freeze and flush flags and the done bit.
// Flags are changed only by clear/set command pairs or by a completion event.
// Assumes: cmd is already masked by the caller; DATA_W >= 8.
module cl_status_ctrl
    import cmdlist_pkg::*;
#(
    parameter int unsigned DATA_W = 32
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  cmd_wr,
    input  logic [2*N_PAIRS-1:0]  cmd,
    input  logic                  done_evt,
    input  logic                  cop_halt,
    input  logic                  cop_broke,
    output logic [DATA_W-1:0]     status,
    output logic                  restart_pulse
);

    logic [N_PAIRS-1:0] flag_q;
    logic [N_PAIRS-1:0] flag_d;
    logic               done_q;

    for (genvar gi = 0; gi < N_PAIRS; gi++) begin : g_pair
        // Next flag value: clear, then set (set wins), then completion override
        always_comb begin
            flag_d[gi] = flag_q[gi];
            if (cmd_wr && cmd[2*gi])   flag_d[gi] = 1'b0;
            if (cmd_wr && cmd[2*gi+1]) flag_d[gi] = 1'b1;
            if (done_evt && (gi == ST_SRC))    flag_d[gi] = 1'b1;
            if (done_evt && (gi == ST_FREEZE)) flag_d[gi] = 1'b0;
        end
    end

    // Flag and done-bit storage
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag_q <= '0;
            done_q <= 1'b0;
        end else begin
            flag_q <= flag_d;
            if (done_evt) done_q <= 1'b1;
        end
    end

    // Restart request when freeze is cleared while the coprocessor is running
    always_ff @(posedge clk) begin
        if (!rst_n) restart_pulse <= 1'b0;
        else        restart_pulse <= cmd_wr && cmd[2*ST_FREEZE] && !cop_halt && !cop_broke;
    end

    // Assemble the readable status word
    always_comb begin
        status = '0;
        status[N_PAIRS-1:0] = flag_q;
        status[ST_DONE]     = done_q;
    end

endmodule

// File: rtl/cl_ptr_bank.sv
// Pointer bank: start, end and current pointers of the command list.
// A start write also reloads current; current has no direct write path.
// Assumes: at most one of wr_start / wr_end is high in a cycle.
module cl_ptr_bank
    import cmdlist_pkg::*;
#(
    parameter int unsigned DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_start,
    input  logic              wr_end,
    input  logic [DATA_W-1:0] wdata,
    input  logic [DATA_W-1:0] wmask,
    output logic [DATA_W-1:0] start_q,
    output logic [DATA_W-1:0] end_q,
    output logic [DATA_W-1:0] cur_q
);

    logic [DATA_W-1:0] start_new;

    // Merged value a start write would store
    assign start_new = (start_q & ~wmask) | (wdata & wmask);

    // Pointer storage with masked writes
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            start_q <= '0;
            end_q   <= '0;
            cur_q   <= '0;
        end else begin
            if (wr_start) begin
                start_q <= start_new;
                cur_q   <= start_new;
            end
            if (wr_end) end_q <= (end_q & ~wmask) | (wdata & wmask);
        end
    end

endmodule

// File: rtl/cl_span_bank.sv
// Span register bank: N_SPAN plain storage words with per-bit masked writes.
// Assumes: wr_en is one-hot or zero.
module cl_span_bank #(
    parameter int unsigned DATA_W = 32,
    parameter int unsigned N_SPAN = 4
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [N_SPAN-1:0]        wr_en,
    input  logic [DATA_W-1:0]        wdata,
    input  logic [DATA_W-1:0]        wmask,
    output logic [N_SPAN*DATA_W-1:0] span_flat
);

    for (genvar gs = 0; gs < N_SPAN; gs++) begin : g_span
        logic [DATA_W-1:0] word_q;
        // One span word with masked write
        always_ff @(posedge clk) begin
            if (!rst_n)         word_q <= '0;
            else if (wr_en[gs]) word_q <= (word_q & ~wmask) | (wdata & wmask);
        end
        assign span_flat[gs*DATA_W +: DATA_W] = word_q;
    end

endmodule

// File: rtl/cmdlist_ctrl_regs.sv
// Top: command-list control register block. Decodes the register bus and
// routes writes to the pointer, status and span units. Provides a
// combinational read mux and the registered host interrupt pulse.
// Assumes: one write per bus_wr cycle; DATA_W fixed at 32 by the package helper.
module cmdlist_ctrl_regs
    import cmdlist_pkg::*;
#(
    parameter int unsigned DATA_W = 32,
    parameter int unsigned ADDR_W = 4,
    parameter int unsigned N_SPAN = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic [DATA_W-1:0] bus_wmask,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              done_evt,
    input  logic              cop_halt,
    input  logic              cop_broke,
    output logic              irq_pulse,
    output logic              task_restart
);

    localparam int unsigned CMD_W = 2 * N_PAIRS;

    logic                     sel_start, sel_end, sel_status;
    logic [N_SPAN-1:0]        sel_span;
    logic [CMD_W-1:0]         stat_cmd;
    logic [DATA_W-1:0]        start_q, end_q, cur_q, status_q;
    logic [N_SPAN*DATA_W-1:0] span_flat;

    // Write address decode
    always_comb begin
        sel_start  = bus_wr && (bus_addr == ADDR_W'(A_START));
        sel_end    = bus_wr && (bus_addr == ADDR_W'(A_END));
        sel_status = bus_wr && (bus_addr == ADDR_W'(A_STATUS));
        for (int k = 0; k < N_SPAN; k++)
            sel_span[k] = bus_wr && (bus_addr == ADDR_W'(A_SPAN0 + k));
    end

    // Effective status commands: only masked bits act
    assign stat_cmd = bus_wdata[CMD_W-1:0] & bus_wmask[CMD_W-1:0];

    cl_ptr_bank #(.DATA_W(DATA_W)) u_ptr (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_start (sel_start),
        .wr_end   (sel_end),
        .wdata    (bus_wdata),
        .wmask    (bus_wmask),
        .start_q  (start_q),
        .end_q    (end_q),
        .cur_q    (cur_q)
    );

    cl_status_ctrl #(.DATA_W(DATA_W)) u_stat (
        .clk           (clk),
        .rst_n         (rst_n),
        .cmd_wr        (sel_status),
        .cmd           (stat_cmd),
        .done_evt      (done_evt),
        .cop_halt      (cop_halt),
        .cop_broke     (cop_broke),
        .status        (status_q),
        .restart_pulse (task_restart)
    );

    cl_span_bank #(.DATA_W(DATA_W), .N_SPAN(N_SPAN)) u_span (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (sel_span),
        .wdata     (bus_wdata),
        .wmask     (bus_wmask),
        .span_flat (span_flat)
    );

    // Host interrupt pulse on end write or completion
    always_ff @(posedge clk) begin
        if (!rst_n) irq_pulse <= 1'b0;
        else        irq_pulse <= sel_end || done_evt;
    end

    // Combinational read mux; read-only and unmapped words return zero
    always_comb begin
        bus_rdata = '0;
        if (bus_addr == ADDR_W'(A_START))   bus_rdata = start_q;
        if (bus_addr == ADDR_W'(A_END))     bus_rdata = end_q;
        if (bus_addr == ADDR_W'(A_CURRENT)) bus_rdata = cur_q;
        if (bus_addr == ADDR_W'(A_STATUS))  bus_rdata = status_q;
        for (int k = 0; k < N_SPAN; k++)
            if (bus_addr == ADDR_W'(A_SPAN0 + k))
                bus_rdata = span_flat[k*DATA_W +: DATA_W];
    end

endmodule

// File: rtl/cmdlist_ctrl_regs_chk.sv
// Checker: temporal properties of the command-list control register block.
// Attached to every instance of the top module by the bind below.
module cmdlist_ctrl_regs_chk
    import cmdlist_pkg::*;
#(
    parameter int unsigned DATA_W = 32,
    parameter int unsigned ADDR_W = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_wr,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [DATA_W-1:0] bus_wdata,
    input logic [DATA_W-1:0] bus_wmask,
    input logic              done_evt,
    input logic              cop_halt,
    input logic              cop_broke,
    input logic              irq_pulse,
    input logic              task_restart,
    input logic [DATA_W-1:0] status_q,
    input logic [DATA_W-1:0] start_q,
    input logic [DATA_W-1:0] cur_q
);

    p_reset_clear_r1: assert property (@(posedge clk)
        !rst_n |=> (status_q == '0 && cur_q == '0 && start_q == '0 && !irq_pulse && !task_restart));

    p_mask_keep_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == ADDR_W'(A_START)) |=>
            (((start_q ^ $past(start_q)) & ~$past(bus_wmask)) == '0));

    p_mask_take_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == ADDR_W'(A_START)) |=>
            (((start_q ^ $past(bus_wdata)) & $past(bus_wmask)) == '0));

    p_start_to_cur_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == ADDR_W'(A_START)) |=> (cur_q == start_q));

    p_end_irq_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == ADDR_W'(A_END)) |=> irq_pulse);

    p_irq_cause_r4: assert property (@(posedge clk) disable iff (!rst_n)
        irq_pulse |-> $past((bus_wr && bus_addr == ADDR_W'(A_END)) || done_evt));

    p_restart_cause_r7: assert property (@(posedge clk) disable iff (!rst_n)
        task_restart |-> $past(bus_wr && bus_addr == ADDR_W'(A_STATUS) &&
                               bus_wdata[2] && bus_wmask[2] && !cop_halt && !cop_broke));

    p_current_ro_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == ADDR_W'(A_CURRENT)) |=> $stable(cur_q));

    p_done_status_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done_evt |=> (status_q[ST_DONE] && status_q[ST_SRC] && !status_q[ST_FREEZE] && irq_pulse));

endmodule

bind cmdlist_ctrl_regs cmdlist_ctrl_regs_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .bus_wr       (bus_wr),
    .bus_addr     (bus_addr),
    .bus_wdata    (bus_wdata),
    .bus_wmask    (bus_wmask),
    .done_evt     (done_evt),
    .cop_halt     (cop_halt),
    .cop_broke    (cop_broke),
    .irq_pulse    (irq_pulse),
    .task_restart (task_restart),
    .status_q     (status_q),
    .start_q      (start_q),
    .cur_q        (cur_q)
);

// File: tb/sim_cmdlist_ctrl_regs.sv
// Bench: directed corner cases plus seeded random traffic, checked against
// a register model kept in bench functions.
module sim_cmdlist_ctrl_regs;

    localparam int NS = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_wmask = '0;
    logic [31:0] bus_rdata;
    logic        done_evt = 1'b0;
    logic        cop_halt = 1'b0;
    logic        cop_broke = 1'b0;
    logic        irq_pulse;
    logic        task_restart;

    int n_chk = 0;
    int n_bad = 0;

    logic [31:0] m_start = '0, m_end = '0, m_cur = '0, m_stat = '0;
    logic [31:0] m_span [NS];

    always #10 clk = ~clk;

    cmdlist_ctrl_regs u0 (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_wmask(bus_wmask), .bus_rdata(bus_rdata),
        .done_evt(done_evt), .cop_halt(cop_halt), .cop_broke(cop_broke),
        .irq_pulse(irq_pulse), .task_restart(task_restart)
    );

    function automatic logic [31:0] f_merge(logic [31:0] o, logic [31:0] d, logic [31:0] m);
        return (o & ~m) | (d & m);
    endfunction

    // Status model: clear then set per pair, completion overrides
    function automatic logic [31:0] f_status(logic [31:0] s, logic wr, logic [5:0] c, logic dn);
        for (int i = 0; i < 3; i++) begin
            if (wr && c[2*i])   s[i] = 1'b0;
            if (wr && c[2*i+1]) s[i] = 1'b1;
        end
        if (dn) begin
            s[1] = 1'b0;
            s[0] = 1'b1;
            s[7] = 1'b1;
        end
        return s;
    endfunction

    function automatic logic [31:0] f_read(int a);
        case (a)
            0: return m_start;
            1: return m_end;
            2: return m_cur;
            3: return m_stat;
            8, 9, 10, 11: return m_span[a-8];
            default: return 32'h0;
        endcase
    endfunction

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // One bus cycle; model updated at the edge, pulses checked after it
    task automatic cyc(logic wr, int a, logic [31:0] d, logic [31:0] m,
                       logic dn, logic h, logic b);
        logic e_irq, e_rs;
        @(negedge clk);
        bus_wr = wr; bus_addr = 4'(a); bus_wdata = d; bus_wmask = m;
        done_evt = dn; cop_halt = h; cop_broke = b;
        @(posedge clk);
        #1;
        e_irq = (wr && a == 1) || dn;
        e_rs  = wr && a == 3 && d[2] && m[2] && !h && !b;
        m_stat = f_status(m_stat, wr && a == 3, d[5:0] & m[5:0], dn);
        if (wr && a == 0) begin
            m_start = f_merge(m_start, d, m);
            m_cur   = m_start;
        end
        if (wr && a == 1) m_end = f_merge(m_end, d, m);
        if (wr && a >= 8 && a < 8 + NS) m_span[a-8] = f_merge(m_span[a-8], d, m);
        bus_wr = 1'b0; done_evt = 1'b0;
        chk("R4 R9 irq_pulse", 32'(irq_pulse), 32'(e_irq));
        chk("R7 R10 task_restart", 32'(task_restart), 32'(e_rs));
    endtask

    task automatic rd(int a, string tag);
        bus_addr = 4'(a);
        #1;
        chk(tag, bus_rdata, f_read(a));
    endtask

    initial begin
        #(64'd20 * 64'd200000);
        n_bad++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
        $finish;
    end

    initial begin
        for (int i = 0; i < NS; i++) m_span[i] = '0;
        void'($urandom(32'd20240611));
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1: everything zero after reset
        for (int a = 0; a < 16; a++) rd(a, "R1 reset value");
        chk("R1 irq after reset", 32'(irq_pulse), 32'h0);
        chk("R1 restart after reset", 32'(task_restart), 32'h0);

        // R2/R3: partial-mask start write reloads current
        cyc(1, 0, 32'hA5A5_A5A5, 32'hFFFF_0000, 0, 0, 0);
        rd(0, "R2 masked start");
        rd(2, "R3 current reload");
        cyc(1, 0, 32'h0000_3C3C, 32'h0000_00FF, 0, 0, 0);
        rd(0, "R2 second masked start");
        rd(2, "R3 current follows merge");

        // R4: end write pulses interrupt
        cyc(1, 1, 32'h1234_5678, 32'h0000_FFFF, 0, 0, 0);
        rd(1, "R2 masked end");
        cyc(0, 0, 32'h0, 32'h0, 0, 0, 0);

        // R5/R6: both bits of every pair, set wins; R7 restart
        cyc(1, 3, 32'h0000_003F, 32'hFFFF_FFFF, 0, 0, 0);
        rd(3, "R5 R6 set wins");
        // R7: clear freeze while halted, no restart
        cyc(1, 3, 32'h0000_0004, 32'hFFFF_FFFF, 0, 1, 0);
        rd(3, "R6 freeze cleared");
        cyc(1, 3, 32'h0000_0015, 32'hFFFF_FFFF, 0, 0, 1);
        rd(3, "R5 R6 all cleared");
        // R10: zero mask does nothing
        cyc(1, 3, 32'h0000_0008, 32'hFFFF_FFFF, 0, 0, 0);
        cyc(1, 3, 32'h0000_003F, 32'h0000_0000, 0, 0, 0);
        rd(3, "R10 zero mask");

        // R8: read-only and unmapped words ignore writes
        cyc(1, 2, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 0, 0, 0);
        rd(2, "R8 current ignores write");
        for (int a = 4; a < 8; a++) begin
            cyc(1, a, 32'hDEAD_BEEF, 32'hFFFF_FFFF, 0, 0, 0);
            rd(a, "R8 read-only word");
        end
        cyc(1, 13, 32'hDEAD_BEEF, 32'hFFFF_FFFF, 0, 0, 0);
        rd(13, "R8 unmapped word");

        // R9: completion overrides a concurrent freeze set
        cyc(1, 3, 32'h0000_0009, 32'hFFFF_FFFF, 1, 0, 0);
        rd(3, "R9 completion wins");

        // R2: span word
        cyc(1, 9, 32'hCAFE_F00D, 32'h0F0F_0F0F, 0, 0, 0);
        rd(9, "R2 span masked");

        // Random traffic
        for (int n = 0; n < 600; n++) begin
            int a;
            logic [31:0] m;
            a = int'($urandom % 16);
            m = ($urandom % 3 == 0) ? 32'hFFFF_FFFF : $urandom;
            cyc(($urandom % 4) != 0, a, $urandom, m,
                ($urandom % 6) == 0, ($urandom % 4) == 0, ($urandom % 4) == 0);
            rd(a, "R2 R8 random read");
            rd(3, "R5 R6 R9 random status");
            rd(2, "R3 random current");
        end

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
        $finish;
    end

endmodule